// File: doc/BRIEF.md
# Four-State Configuration Strap Decoder

This block reads two board-level configuration straps. Each strap can be in one of four conditions: tied to the supply, tied to ground, left open so that it rests near mid-supply, or driven by a free-running 25 MHz clock. Outside the block, each strap feeds two threshold comparators. One trips when the pin sits above an upper threshold and the other trips when it sits below a lower threshold. The block receives only those two digital bits per strap.

After a hardware reset is released, the block runs a fixed observation window on a reference clock. The comparator bits pass through a synchroniser. Transitions are counted on both comparator bits, and the most recent steady level is tracked. When the window closes, the block stores a 2-bit code per strap and pulses a one-cycle valid strobe. The stored codes hold until the next hardware reset.

The two stored codes are mapped into power-on defaults. These are a 4-bit link-ability advertisement set and a 3-bit mode word (auto-negotiation enable, 100 Mb/s speed, full duplex). A forced mode or an auto-negotiation advertisement is chosen from the strap combination.

Top module: `strap_quad_decoder`

## Requirements
- R1: A strap whose synchronised comparator pair (hi,lo) is held steady is coded as follows: (1,0) gives HIGH = 2'b01, (0,1) gives LOW = 2'b00, (0,0) gives FLOAT = 2'b10. The pair (1,1) never updates the level.
- R2: A strap is coded CLOCK = 2'b11 when both its hi and lo comparator bits show at least MIN_EDGES transitions (default 8) inside the window.
- R3: When either comparator bit has fewer than MIN_EDGES transitions, the code is the last level seen on two consecutive synchronised samples. For example, 8 alternating steps (1,0),(0,1),... starting from (0,0) give a LOW code, and 9 such steps give CLOCK.
- R4: strap_valid pulses high for exactly one cycle, WIN_CYCLES rising edges after hardware reset is released. strap_code takes its new value in that same cycle.
- R5: After the valid pulse, strap_code, adv_default and mode_default ignore all comparator activity until the next hardware reset. A new hardware reset samples the straps again.
- R6: During reset, strap_code is 4'b0000 and strap_valid is 0.
- R7: strap_code[1:0] is strap 0 and strap_code[3:2] is strap 1. When strap 0 is FLOAT, mode_default = 3'b100 (auto-negotiation on). adv_default (bit3 100FD, bit2 100HD, bit1 10FD, bit0 10HD) then follows strap 1: LOW gives 0011, HIGH gives 1100, FLOAT gives 1111, CLOCK gives 1010.
- R8: When strap 0 is not FLOAT, the mode is forced. Speed is 100 when strap 1 is HIGH or CLOCK. Duplex is full when strap 0 is HIGH or CLOCK. mode_default = {0,speed,duplex}, and adv_default has the single bit at index {speed,duplex} set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Active-low hardware reset; its release starts the window |
| cmp_hi | input | 2 | Per-strap upper-threshold comparator output |
| cmp_lo | input | 2 | Per-strap lower-threshold comparator output |
| strap_code | output | 4 | Latched codes, strap 1 in [3:2], strap 0 in [1:0] |
| strap_valid | output | 1 | One-cycle strobe when the codes are latched |
| adv_default | output | 4 | Default advertisement bits |
| mode_default | output | 3 | Default {autoneg, speed100, full duplex} |

## Verification
The bench targets the transition-count boundary. Exactly eight alternating steps must still decode as a level, and nine must decode as a clock. A design with an off-by-one threshold, or one that counts only one comparator bit, gets one of these two cases wrong. The bench also drives a strap that switches level mid-window, and a short burst of toggles that ends on a steady level. A design that samples the first level, or that declares a clock too eagerly, reports the wrong code. Finally, the bench toggles every comparator after the window closes. A design that keeps sampling then changes its defaults, and a reset state or a valid pulse that is one cycle off shows up in the per-cycle comparison.

// File: rtl/strap_quad_decoder.sv
module strap_quad_decoder #(
  parameter int WIN_CYCLES = 64,
  parameter int MIN_EDGES  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cmp_hi,
  input  logic [1:0] cmp_lo,
  output logic [3:0] strap_code,
  output logic       strap_valid,
  output logic [3:0] adv_default,
  output logic [2:0] mode_default
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam int WW = $clog2(WIN_CYCLES);
  localparam logic [1:0] C_LOW = 2'b00, C_HIGH = 2'b01, C_FLOAT = 2'b10, C_CLOCK = 2'b11;

  logic          busy;
  logic [WW-1:0] win_cnt;
  logic [1:0]    cand [2];

  for (genvar p = 0; p < 2; p++) begin : g_pin
    logic [1:0]    s1, s2, s3;
    logic [CW-1:0] n_hi, n_lo;
    logic [1:0]    lvl;
    logic [1:0]    seen;

    always_comb begin
      unique case (s2)
        2'b10:   seen = C_HIGH;
        2'b01:   seen = C_LOW;
        default: seen = C_FLOAT;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= '0; s2 <= '0; s3 <= '0;
        n_hi <= '0; n_lo <= '0;
        lvl <= C_FLOAT;
      end else begin
        s1 <= {cmp_hi[p], cmp_lo[p]};
        s2 <= s1;
        s3 <= s2;
        if (busy) begin
          if ((s2[1] ^ s3[1]) && n_hi != CW'(WIN_CYCLES)) n_hi <= n_hi + 1'b1;
          if ((s2[0] ^ s3[0]) && n_lo != CW'(WIN_CYCLES)) n_lo <= n_lo + 1'b1;
          if (s2 == s3 && s2 != 2'b11) lvl <= seen;
        end
      end
    end

    assign cand[p] = (32'(n_hi) >= MIN_EDGES && 32'(n_lo) >= MIN_EDGES) ? C_CLOCK : lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b1;
      win_cnt     <= '0;
      strap_code  <= '0;
      strap_valid <= 1'b0;
    end else begin
      strap_valid <= 1'b0;
      if (busy) begin
        if (win_cnt == WW'(WIN_CYCLES - 1)) begin
          busy        <= 1'b0;
          strap_valid <= 1'b1;
          strap_code  <= {cand[1], cand[0]};
        end else begin
          win_cnt <= win_cnt + 1'b1;
        end
      end
    end
  end

  logic [1:0] c0, c1;
  logic       an_on, spd, fdx;
  assign c0    = strap_code[1:0];
  assign c1    = strap_code[3:2];
  assign an_on = (c0 == C_FLOAT);
  assign spd   = c1[0];
  assign fdx   = c0[0];

  always_comb begin
    if (an_on) begin
      mode_default = 3'b100;
      unique case (c1)
        C_LOW:   adv_default = 4'b0011;
        C_HIGH:  adv_default = 4'b1100;
        C_FLOAT: adv_default = 4'b1111;
        default: adv_default = 4'b1010;
      endcase
    end else begin
      mode_default = {1'b0, spd, fdx};
      adv_default  = 4'b0001 << {spd, fdx};
    end
  end
endmodule

module strap_quad_decoder_chk #(
  parameter int WIN_CYCLES = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] strap_code,
  input logic       strap_valid,
  input logic [3:0] adv_default,
  input logic [2:0] mode_default
);
  localparam int TW = $clog2(WIN_CYCLES + 2) + 1;
  logic [TW-1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != TW'(WIN_CYCLES + 1)) since_rst <= since_rst + 1'b1;
  end

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strap_valid |=> !strap_valid);
  p_window_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strap_valid |-> since_rst == TW'(WIN_CYCLES));
  p_code_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_valid |-> $stable(strap_code));
  p_an_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_default[2] |-> (mode_default[1:0] == 2'b00 && strap_code[1:0] == 2'b10));
  p_forced_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_default[2] |-> $countones(adv_default) == 1);
endmodule

bind strap_quad_decoder strap_quad_decoder_chk #(.WIN_CYCLES(WIN_CYCLES)) chk_i (.*);

// File: tb/strap_quad_decoder_tb_top.sv
module strap_quad_decoder_tb_top;
  localparam int WIN = 64;
  localparam int MINE = 8;
  localparam int K_LOW = 0, K_HIGH = 1, K_FLOAT = 2, K_CLK = 3, K_BURST = 4, K_SWITCH = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cmp_hi = '0, cmp_lo = '0;
  logic [3:0] strap_code, adv_default;
  logic       strap_valid;
  logic [2:0] mode_default;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  strap_quad_decoder #(.WIN_CYCLES(WIN), .MIN_EDGES(MINE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .strap_code(strap_code), .strap_valid(strap_valid),
    .adv_default(adv_default), .mode_default(mode_default));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: per-strap history of samples, edge tallies, steady level
  int m_q [2][$];
  int m_eh [2], m_el [2], m_lvl [2];
  int m_edges, m_code;
  bit m_valid;

  task automatic model_reset();
    for (int p = 0; p < 2; p++) begin
      m_q[p] = {0, 0, 0};
      m_eh[p] = 0; m_el[p] = 0; m_lvl[p] = 2;
    end
    m_edges = 0; m_code = 0; m_valid = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int c [2];
      m_edges++;
      m_valid = (m_edges == WIN);
      for (int p = 0; p < 2; p++)
        c[p] = (m_eh[p] >= MINE && m_el[p] >= MINE) ? 3 : m_lvl[p];
      if (m_valid) m_code = c[1] * 4 + c[0];
      for (int p = 0; p < 2; p++) begin
        int cur, prv;
        cur = m_q[p][1];
        prv = m_q[p][2];
        if (m_edges <= WIN) begin
          if ((cur / 2) != (prv / 2)) m_eh[p]++;
          if ((cur % 2) != (prv % 2)) m_el[p]++;
          if (cur == prv && cur != 3) m_lvl[p] = (cur == 2) ? 1 : (cur == 1) ? 0 : 2;
        end
        m_q[p].push_front({cmp_hi[p], cmp_lo[p]});
        void'(m_q[p].pop_back());
      end
    end
  end

  function automatic int pat(int kind, int n, int cyc);
    int k;
    if (cyc >= WIN + 8) return ((cyc / 2) % 2) ? 2 : 1;
    case (kind)
      K_LOW:   return 1;
      K_HIGH:  return 2;
      K_FLOAT: return 0;
      K_CLK:   return ((cyc / 4) % 2) ? 2 : 1;
      K_BURST: begin
        if (cyc < 4) return 0;
        k = (cyc - 4) / 3 + 1;
        if (k > n) k = n;
        return (k % 2) ? 2 : 1;
      end
      default: return (cyc < 30) ? 1 : 2;
    endcase
  endfunction

  task automatic drive(int k0, int n0, int k1, int n1, int cyc);
    int a, b;
    a = pat(k0, n0, cyc);
    b = pat(k1, n1, cyc);
    cmp_hi = {b[1], a[1]};
    cmp_lo = {b[0], a[0]};
  endtask

  task automatic run_case(string nm, int k0, int n0, int k1, int n1,
                          int e_code, int e_adv, int e_mode, bit chk_rst);
    int vcount, vpos;
    vcount = 0; vpos = -1;
    @(negedge clk);
    rst_n = 1'b0;
    drive(k0, n0, k1, n1, 0);
    repeat (3) @(negedge clk);
    if (chk_rst) begin
      chk({"R6 reset code ", nm}, strap_code, 0);
      chk({"R6 reset valid ", nm}, strap_valid, 0);
    end
    rst_n = 1'b1;
    drive(k0, n0, k1, n1, 0);
    for (int cyc = 1; cyc < WIN + 40; cyc++) begin
      @(negedge clk);
      chk({"R4 model valid ", nm}, strap_valid, m_valid);
      chk({"R5 model code ", nm}, strap_code, m_code);
      if (strap_valid) begin vcount++; vpos = cyc; end
      drive(k0, n0, k1, n1, cyc);
    end
    chk({"R4 valid count ", nm}, vcount, 1);
    chk({"R4 valid edge ", nm}, vpos, WIN);
    chk({"R1 R2 R3 R5 code ", nm}, strap_code, e_code);
    chk({"R7 R8 adv ", nm}, adv_default, e_adv);
    chk({"R7 R8 mode ", nm}, mode_default, e_mode);
  endtask

  initial begin
    run_case("float/float",   K_FLOAT, 0, K_FLOAT, 0, 4'b1010, 4'b1111, 3'b100, 1);
    run_case("high/high",     K_HIGH, 0, K_HIGH, 0,   4'b0101, 4'b1000, 3'b011, 1);
    run_case("low/clock",     K_LOW, 0, K_CLK, 0,     4'b1100, 4'b0100, 3'b010, 0);
    run_case("float/clock",   K_FLOAT, 0, K_CLK, 0,   4'b1110, 4'b1010, 3'b100, 0);
    run_case("float/low",     K_FLOAT, 0, K_LOW, 0,   4'b0010, 4'b0011, 3'b100, 0);
    run_case("float/high",    K_FLOAT, 0, K_HIGH, 0,  4'b0110, 4'b1100, 3'b100, 0);
    run_case("short burst R3",K_BURST, 3, K_LOW, 0,   4'b0001, 4'b0010, 3'b001, 0);
    run_case("switch R3",     K_SWITCH, 0, K_FLOAT, 0,4'b1001, 4'b0010, 3'b001, 0);
    run_case("8 steps R3",    K_HIGH, 0, K_BURST, 8,  4'b0001, 4'b0010, 3'b001, 0);
    run_case("9 steps R2",    K_HIGH, 0, K_BURST, 9,  4'b1101, 4'b1000, 3'b011, 0);
    run_case("clock/low R8",  K_CLK, 0, K_LOW, 0,     4'b0011, 4'b0010, 3'b001, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule